// File: doc/BRIEF.md
# Backplane Negotiation Outcome Resolver

This block turns the outcome of a backplane autonegotiation exchange into operating decisions. It receives the three local advertisement words and the three link-partner ability words, 16 bits each. On a one-cycle strobe it registers four results: the operating mode that both sides share, the transmit and receive pause enables, and a set of flags that describe what the partner offered.

A static strap input chooses what the shared low-speed ability bit means, either 1G or 2.5G. A pause-negotiation enable decides whether the pause outputs are recomputed on a strobe or keep their values. One cycle after each strobe, a done pulse marks that the new results are valid. Reading the words from the management bus, link training and the actual rate change are all done elsewhere.

Top module: `an_resolve`

## Requirements
- R1: After reset, mode_o is 0, both pause outputs and all partner flags are 0, and done_o is 0.
- R2: When resolve_i is high at a rising edge, done_o is high for exactly the following cycle. Every registered output takes its new value in that same cycle. Outputs do not change in any cycle not preceded by a strobe.
- R3: mode_o encoding: 0 = unknown, 1 = KX 1G, 2 = KX 2.5G, 3 = KR 10G. If bit 7 of (local word 2 AND partner word 2) is set, mode_o is 3, whatever bit 5 holds.
- R4: If bit 7 of the ANDed second words is clear and bit 5 is set, mode_o is 2 when slow_is_2g5_i is 1 and 1 when it is 0.
- R5: If neither bit 7 nor bit 5 survives the AND of the second words, mode_o is 0.
- R6: With pause_an_en_i high, if bit 10 is set in both local word 1 and partner word 1, tx_pause_o and rx_pause_o are both 1.
- R7: With pause_an_en_i high, bit 10 not common to both first words, and bit 11 set in both: rx_pause_o=1 and tx_pause_o=0 if local bit 10 is set. If local bit 10 is clear and partner bit 10 is set, tx_pause_o=1 and rx_pause_o=0. In all other cases both are 0.
- R8: With pause_an_en_i low, a strobe leaves tx_pause_o and rx_pause_o unchanged.
- R9: lp_sym_o and lp_asym_o copy partner word 1 bits 10 and 11 on a strobe.
- R10: lp_kr_o copies partner word 2 bit 7. lp_kx1g_o is partner word 2 bit 5 when slow_is_2g5_i=0, else 0. lp_kx2g5_o is partner word 2 bit 5 when slow_is_2g5_i=1, else 0.
- R11: lp_fec_o is set when either bit 15 or bit 14 of partner word 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resolve_i | input | 1 | Resolve strobe |
| slow_is_2g5_i | input | 1 | Speed-set strap: 1 selects 2.5G as the slow mode |
| pause_an_en_i | input | 1 | Enable pause resolution |
| loc_w1_i | input | 16 | Local advertisement word 1 |
| loc_w2_i | input | 16 | Local advertisement word 2 |
| loc_w3_i | input | 16 | Local advertisement word 3 (unused) |
| lp_w1_i | input | 16 | Partner ability word 1 |
| lp_w2_i | input | 16 | Partner ability word 2 |
| lp_w3_i | input | 16 | Partner ability word 3 |
| mode_o | output | 2 | Resolved mode code |
| tx_pause_o | output | 1 | Transmit pause enable |
| rx_pause_o | output | 1 | Receive pause enable |
| lp_sym_o | output | 1 | Partner offers symmetric pause |
| lp_asym_o | output | 1 | Partner offers asymmetric pause |
| lp_kr_o | output | 1 | Partner offers 10G KR |
| lp_kx1g_o | output | 1 | Partner offers 1G KX |
| lp_kx2g5_o | output | 1 | Partner offers 2.5G |
| lp_fec_o | output | 1 | Partner offers FEC |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The in-module assertions check every cycle that done follows each strobe by exactly one cycle, that outputs stay stable between strobes, that the pause outputs hold when pause negotiation is off, and that the two slow-speed flags are never both set. How mode and pause are decided from particular word values is shown only by the bench scenarios. These include the priority of KR over KX, the asymmetric-pause cases on each side, both strap settings, and the FEC mask.

// File: rtl/an_resolve.sv
module an_resolve #(
  parameter int W = 16,
  parameter int SYM_BIT = 10,
  parameter int ASYM_BIT = 11,
  parameter int KR_BIT = 7,
  parameter int KX_BIT = 5,
  parameter int FEC_HI = 15,
  parameter int FEC_LO = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         resolve_i,
  input  logic         slow_is_2g5_i,
  input  logic         pause_an_en_i,
  input  logic [W-1:0] loc_w1_i,
  input  logic [W-1:0] loc_w2_i,
  input  logic [W-1:0] loc_w3_i,
  input  logic [W-1:0] lp_w1_i,
  input  logic [W-1:0] lp_w2_i,
  input  logic [W-1:0] lp_w3_i,
  output logic [1:0]   mode_o,
  output logic         tx_pause_o,
  output logic         rx_pause_o,
  output logic         lp_sym_o,
  output logic         lp_asym_o,
  output logic         lp_kr_o,
  output logic         lp_kx1g_o,
  output logic         lp_kx2g5_o,
  output logic         lp_fec_o,
  output logic         done_o
);
  localparam logic [1:0] M_UNK = 2'd0, M_KX1 = 2'd1, M_KX25 = 2'd2, M_KR = 2'd3;

  logic [W-1:0] common2;
  logic         both_sym, both_asym;
  logic [1:0]   mode_n;
  logic         tx_n, rx_n;
  logic         loc3_unused;

  assign loc3_unused = ^loc_w3_i;
  assign common2   = loc_w2_i & lp_w2_i;
  assign both_sym  = loc_w1_i[SYM_BIT] & lp_w1_i[SYM_BIT];
  assign both_asym = loc_w1_i[ASYM_BIT] & lp_w1_i[ASYM_BIT];

  always_comb begin
    if (common2[KR_BIT])      mode_n = M_KR;
    else if (common2[KX_BIT]) mode_n = slow_is_2g5_i ? M_KX25 : M_KX1;
    else                      mode_n = M_UNK;
  end

  always_comb begin
    tx_n = 1'b0;
    rx_n = 1'b0;
    if (both_sym) begin
      tx_n = 1'b1;
      rx_n = 1'b1;
    end else if (both_asym) begin
      if (loc_w1_i[SYM_BIT])     rx_n = 1'b1;
      else if (lp_w1_i[SYM_BIT]) tx_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o     <= M_UNK;
      tx_pause_o <= 1'b0;
      rx_pause_o <= 1'b0;
      lp_sym_o   <= 1'b0;
      lp_asym_o  <= 1'b0;
      lp_kr_o    <= 1'b0;
      lp_kx1g_o  <= 1'b0;
      lp_kx2g5_o <= 1'b0;
      lp_fec_o   <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= resolve_i;
      if (resolve_i) begin
        mode_o     <= mode_n;
        lp_sym_o   <= lp_w1_i[SYM_BIT];
        lp_asym_o  <= lp_w1_i[ASYM_BIT];
        lp_kr_o    <= lp_w2_i[KR_BIT];
        lp_kx1g_o  <= lp_w2_i[KX_BIT] & ~slow_is_2g5_i;
        lp_kx2g5_o <= lp_w2_i[KX_BIT] & slow_is_2g5_i;
        lp_fec_o   <= lp_w3_i[FEC_HI] | lp_w3_i[FEC_LO];
        if (pause_an_en_i) begin
          tx_pause_o <= tx_n;
          rx_pause_o <= rx_n;
        end
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && resolve_i |=> done_o);
  assert_done_only_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !resolve_i |=> !done_o);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !resolve_i |=> $stable(mode_o) && $stable(lp_fec_o) && $stable(lp_kr_o));
  assert_pause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !pause_an_en_i |=> $stable(tx_pause_o) && $stable(rx_pause_o));
  assert_slow_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_kx1g_o, lp_kx2g5_o}));
  assert_asym_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && pause_an_en_i && (tx_pause_o ^ rx_pause_o) |-> lp_asym_o);
endmodule

// File: tb/an_resolve_bench.sv
module an_resolve_bench;
  logic clk = 0, rst_n = 0, resolve_i = 0, slow = 0, pen = 0;
  logic [15:0] l1 = 0, l2 = 0, l3 = 0, p1 = 0, p2 = 0, p3 = 0;
  logic [1:0] mode_o;
  logic tx_o, rx_o, sym_o, asym_o, kr_o, kx1_o, kx25_o, fec_o, done_o;
  int checks = 0, fails = 0;
  logic [11:0] expq[$];
  string tagq[$];
  bit wd_hit = 0;

  always #10 clk = ~clk;

  an_resolve u_an_resolve (.clk(clk), .rst_n(rst_n), .resolve_i(resolve_i),
    .slow_is_2g5_i(slow), .pause_an_en_i(pen), .loc_w1_i(l1), .loc_w2_i(l2),
    .loc_w3_i(l3), .lp_w1_i(p1), .lp_w2_i(p2), .lp_w3_i(p3), .mode_o(mode_o),
    .tx_pause_o(tx_o), .rx_pause_o(rx_o), .lp_sym_o(sym_o), .lp_asym_o(asym_o),
    .lp_kr_o(kr_o), .lp_kx1g_o(kx1_o), .lp_kx2g5_o(kx25_o), .lp_fec_o(fec_o),
    .done_o(done_o));

  function automatic logic [11:0] outs();
    return {mode_o, tx_o, rx_o, sym_o, asym_o, kr_o, kx1_o, kx25_o, fec_o, done_o, 1'b0};
  endfunction

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic ptx = 0, prx = 0;

  task automatic drive(string tag, logic s, logic pe, logic [15:0] a1, logic [15:0] a2,
                       logic [15:0] b1, logic [15:0] b2, logic [15:0] b3);
    logic [1:0] m;
    logic [15:0] c;
    logic t, r;
    c = a2 & b2;
    m = c[7] ? 2'd3 : (c[5] ? (s ? 2'd2 : 2'd1) : 2'd0);
    t = ptx; r = prx;
    if (pe) begin
      t = 0; r = 0;
      if (a1[10] && b1[10]) begin t = 1; r = 1; end
      else if (a1[11] && b1[11]) begin
        if (a1[10]) r = 1; else if (b1[10]) t = 1;
      end
    end
    ptx = t; prx = r;
    expq.push_back({m, t, r, b1[10], b1[11], b2[7], b2[5] & ~s, b2[5] & s,
                    b3[15] | b3[14], 1'b1, 1'b0});
    tagq.push_back(tag);
    @(negedge clk);
    slow = s; pen = pe; l1 = a1; l2 = a2; p1 = b1; p2 = b2; p3 = b3;
    l3 = 16'hFFFF; resolve_i = 1;
    @(negedge clk);
    resolve_i = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (expq.size() == 0) chk("R2 spurious done", outs(), 12'h0);
      else chk(tagq.pop_front(), outs(), expq.pop_front());
    end
  end

  initial begin
    #40000;
    wd_hit = 1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", outs(), 12'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", outs(), 12'h0);
    drive("R3 KR priority", 0, 1, 0, 16'h00A0, 0, 16'h00A0, 0);
    drive("R4 KX1G strap0", 0, 1, 0, 16'h0020, 0, 16'h0020, 0);
    drive("R4 KX2G5 strap1", 1, 1, 0, 16'h0020, 0, 16'h00A0, 0);
    drive("R5 no common", 0, 1, 0, 16'h0080, 0, 16'h0020, 0);
    drive("R6 sym both", 0, 1, 16'h0400, 0, 16'h0C00, 0, 0);
    drive("R7 rx asym", 0, 1, 16'h0C00, 0, 16'h0800, 0, 0);
    drive("R8 hold pause", 0, 0, 0, 0, 0, 0, 0);
    drive("R7 tx asym", 0, 1, 16'h0800, 0, 16'h0C00, 0, 0);
    drive("R7 no pause", 0, 1, 16'h0800, 0, 16'h0400, 0, 0);
    drive("R6 set then", 0, 1, 16'h0400, 0, 16'h0400, 0, 0);
    drive("R8 hold high", 1, 0, 0, 0, 16'h0800, 16'h0020, 0);
    drive("R9 partner pause flags", 0, 1, 0, 0, 16'h0C00, 0, 0);
    drive("R10 partner speed flags", 1, 1, 0, 0, 0, 16'h00A0, 0);
    drive("R10 partner kx1g", 0, 1, 0, 0, 0, 16'h0020, 0);
    drive("R11 fec hi", 0, 1, 0, 0, 0, 0, 16'h8000);
    drive("R11 fec lo", 0, 1, 0, 0, 0, 0, 16'h4000);
    drive("R11 no fec", 0, 1, 0, 0, 0, 0, 16'h3FFF);
    repeat (2) @(negedge clk);
    chk("R2 queue drained", {4'd0, 8'(expq.size())}, 12'h0);
    if (wd_hit) begin checks++; fails++; $display("FAIL watchdog"); end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #40000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule